// File: doc/BRIEF.md
# Execute-Stage Fault Detector

This block sits beside the execute stage of a 32-bit integer pipeline and decides, in the same cycle as the operation, whether the operation must trap. It receives an already decoded operation kind, the two register operands, the sign-extended immediate and the address of the following instruction. It forms the sum or difference, the effective address of a load or store, or the target of a register jump. From these it raises either a signed arithmetic overflow or a misaligned-address fault.

When a trap is raised, the block withholds the destination-register write enable. For address faults it also latches the offending address into a bad-address register, which the rest of the core can read. A jump-and-link through a register is the one exception to withholding: the link value is always written, even when the target then turns out to be misaligned.

Exception flags, the cause code, the write enable and the write data are combinational on the inputs. The bad-address register is the only state.

Top module: `exec_fault_unit`

## Requirements
- R1: Operation kind is a 4-bit code: 0 none, 1 signed add, 2 unsigned add, 3 signed subtract, 4 unsigned subtract, 5 signed add-immediate, 6 unsigned add-immediate, 7 halfword load, 8 word load, 9 halfword store, 10 word store, 11 register jump, 12 register jump-and-link. For kinds 1 and 5, overflow is raised when both addends carry the same sign bit and the sum's sign bit differs; the cause is then 12 and no register write is enabled.
- R2: For kind 3, a−b raises overflow (cause 12, no write) exactly when the true signed difference does not fit in 32 bits.
- R3: Kinds 2, 4 and 6 never raise an exception; they always enable the write, with the 32-bit wrapped sum or difference as write data. Without overflow, kinds 1, 3 and 5 write their result in the same way.
- R4: The effective address of kinds 7 to 10 is operand A plus the immediate. Halfword kinds fault when bit 0 of that address is 1. Word kinds fault when bits 1:0 are not 00. Register-jump targets (operand A) fault when bits 1:0 are not 00.
- R5: A misaligned load or jump target reports cause 4. A misaligned store reports cause 5. An aligned load enables the write, with the effective address on the write-data output, while a store never enables the write.
- R6: Kind 12 always enables the write, with the next-instruction address as data, whether or not its target faults. Kind 11 never writes.
- R7: The bad-address register resets to 0. It loads the faulting address on the clock edge at which an address fault is present, and holds its value on all other edges, including overflow traps.
- R8: With the valid input low, no exception is raised, no write is enabled and the bad-address register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is present this cycle |
| opKind | input | 4 | Decoded operation kind (see R1) |
| opA | input | 32 | First register operand / base / jump target |
| opB | input | 32 | Second register operand |
| immExt | input | 32 | Sign-extended immediate |
| nextPc | input | 32 | Address of the following instruction (link value) |
| excTaken | output | 1 | Exception raised this cycle |
| excCode | output | 5 | Cause code: 4, 5 or 12; 0 when no exception |
| writeEn | output | 1 | Destination register write allowed |
| writeData | output | 32 | Result, effective address or link value |
| badAddr | output | 32 | Last captured faulting address |

## Verification
The hardest cases are the sign-boundary operand pairs, where overflow turns on or off with a single bit. Random operands almost never land there. The bench therefore sweeps every ordered pair from a set of values clustered around the most positive and most negative integers, zero and minus one. The sweep runs through every arithmetic kind, and the expected flag comes from widened signed arithmetic rather than from sign-bit rules. Address faults are reached by sweeping base and offset low bits exhaustively for every access width. After each edge, the bench compares the bad-address register against a model that only moves on address faults, so an overflow that follows a fault shows whether the register wrongly captures.

// File: rtl/exec_fault_pkg.sv
package exec_fault_pkg;

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CAUSE_NONE  = 5'd0;
  localparam logic [CODE_W-1:0] CAUSE_LDADR = 5'd4;
  localparam logic [CODE_W-1:0] CAUSE_STADR = 5'd5;
  localparam logic [CODE_W-1:0] CAUSE_OVF   = 5'd12;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_ADD   = 4'd1,
    OP_ADDU  = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBU  = 4'd4,
    OP_ADDI  = 4'd5,
    OP_ADDIU = 4'd6,
    OP_LDH   = 4'd7,
    OP_LDW   = 4'd8,
    OP_STH   = 4'd9,
    OP_STW   = 4'd10,
    OP_JR    = 4'd11,
    OP_JALR  = 4'd12
  } opKind_e;

  // strobes from control into datapath
  typedef struct packed {
    logic useImm;    // second addend is the immediate
    logic subtract;  // form a - b instead of a + b
    logic chkOvf;    // signed overflow is a trap
    logic accHalf;   // halfword alignment check on the sum
    logic accWord;   // word alignment check on the sum
    logic isJump;    // word alignment check on operand A
    logic linkWr;    // write data is the link value
  } dpStrobe_s;

endpackage

// File: rtl/exec_fault_dp.sv
module exec_fault_dp
  import exec_fault_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_s         strobe,
  input  logic              captureEn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] immExt,
  input  logic [DATA_W-1:0] nextPc,
  output logic              ovfFlag,
  output logic              misAlign,
  output logic [DATA_W-1:0] resultData,
  output logic [DATA_W-1:0] badAddr
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addendB;
  logic [DATA_W-1:0] sumRes;
  logic [DATA_W-1:0] chkAddr;
  logic              addOvf;
  logic              subOvf;
  logic [DATA_W-1:0] subMix;

  assign addendB = strobe.useImm ? immExt : opB;
  assign sumRes  = strobe.subtract ? (opA - addendB) : (opA + addendB);

  // add: like-signed addends, result sign flips
  assign addOvf = (opA[MSB] == addendB[MSB]) && (sumRes[MSB] != opA[MSB]);
  // sub: result differs in sign from a while b matches the result
  assign subMix = (opA ^ sumRes) & (~addendB ^ sumRes);
  assign subOvf = subMix[MSB];

  assign ovfFlag = strobe.chkOvf && (strobe.subtract ? subOvf : addOvf);

  assign chkAddr = strobe.isJump ? opA : sumRes;

  always_comb begin
    misAlign = 1'b0;
    if (strobe.accHalf) begin
      misAlign = chkAddr[0];
    end else if (strobe.accWord || strobe.isJump) begin
      misAlign = |chkAddr[1:0];
    end
  end

  always_comb begin
    if (strobe.linkWr) begin
      resultData = nextPc;
    end else if (strobe.isJump) begin
      resultData = opA;
    end else begin
      resultData = sumRes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      badAddr <= '0;
    end else if (captureEn) begin
      badAddr <= chkAddr;
    end
  end

endmodule

// File: rtl/exec_fault_ctrl.sv
module exec_fault_ctrl
  import exec_fault_pkg::*;
(
  input  logic              opValid,
  input  logic [3:0]        opKind,
  input  logic              ovfFlag,
  input  logic              misAlign,
  output dpStrobe_s         strobe,
  output logic              captureEn,
  output logic              excTaken,
  output logic [CODE_W-1:0] excCode,
  output logic              writeEn
);

  opKind_e kind;
  logic    isArith;
  logic    isLoad;
  logic    isStore;

  assign kind = opKind_e'(opKind);

  always_comb begin
    strobe  = '0;
    isArith = 1'b0;
    isLoad  = 1'b0;
    isStore = 1'b0;
    case (kind)
      OP_ADD:   begin isArith = 1'b1; strobe.chkOvf = 1'b1; end
      OP_ADDU:  begin isArith = 1'b1; end
      OP_SUB:   begin isArith = 1'b1; strobe.chkOvf = 1'b1; strobe.subtract = 1'b1; end
      OP_SUBU:  begin isArith = 1'b1; strobe.subtract = 1'b1; end
      OP_ADDI:  begin isArith = 1'b1; strobe.chkOvf = 1'b1; strobe.useImm = 1'b1; end
      OP_ADDIU: begin isArith = 1'b1; strobe.useImm = 1'b1; end
      OP_LDH:   begin isLoad  = 1'b1; strobe.useImm = 1'b1; strobe.accHalf = 1'b1; end
      OP_LDW:   begin isLoad  = 1'b1; strobe.useImm = 1'b1; strobe.accWord = 1'b1; end
      OP_STH:   begin isStore = 1'b1; strobe.useImm = 1'b1; strobe.accHalf = 1'b1; end
      OP_STW:   begin isStore = 1'b1; strobe.useImm = 1'b1; strobe.accWord = 1'b1; end
      OP_JR:    begin strobe.isJump = 1'b1; end
      OP_JALR:  begin strobe.isJump = 1'b1; strobe.linkWr = 1'b1; end
      default:  begin end
    endcase
  end

  logic addrFault;
  logic ovfFault;

  assign addrFault = opValid && misAlign;
  assign ovfFault  = opValid && ovfFlag;

  assign captureEn = addrFault;
  assign excTaken  = addrFault || ovfFault;

  always_comb begin
    excCode = CAUSE_NONE;
    if (ovfFault) begin
      excCode = CAUSE_OVF;
    end else if (addrFault) begin
      excCode = isStore ? CAUSE_STADR : CAUSE_LDADR;
    end
  end

  // link is written before the target check, so a faulting JALR still writes
  assign writeEn = opValid &&
                   ((isArith && !ovfFlag) || (isLoad && !misAlign) || strobe.linkWr);

endmodule

// File: rtl/exec_fault_unit.sv
module exec_fault_unit
  import exec_fault_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opKind,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] immExt,
  input  logic [DATA_W-1:0] nextPc,
  output logic              excTaken,
  output logic [CODE_W-1:0] excCode,
  output logic              writeEn,
  output logic [DATA_W-1:0] writeData,
  output logic [DATA_W-1:0] badAddr
);

  dpStrobe_s strobe;
  logic      captureEn;
  logic      ovfFlag;
  logic      misAlign;

  exec_fault_ctrl ctrl_i (
    .opValid   (opValid),
    .opKind    (opKind),
    .ovfFlag   (ovfFlag),
    .misAlign  (misAlign),
    .strobe    (strobe),
    .captureEn (captureEn),
    .excTaken  (excTaken),
    .excCode   (excCode),
    .writeEn   (writeEn)
  );

  exec_fault_dp #(.DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .captureEn  (captureEn),
    .opA        (opA),
    .opB        (opB),
    .immExt     (immExt),
    .nextPc     (nextPc),
    .ovfFlag    (ovfFlag),
    .misAlign   (misAlign),
    .resultData (writeData),
    .badAddr    (badAddr)
  );

endmodule

// File: rtl/exec_fault_unit_chk.sv
module exec_fault_unit_chk
  import exec_fault_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opKind,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] immExt,
  input logic [DATA_W-1:0] nextPc,
  input logic              excTaken,
  input logic [CODE_W-1:0] excCode,
  input logic              writeEn,
  input logic [DATA_W-1:0] writeData,
  input logic [DATA_W-1:0] badAddr
);

  logic isStoreKind;
  logic isLdStKind;
  assign isStoreKind = (opKind == OP_STH) || (opKind == OP_STW);
  assign isLdStKind  = (opKind >= OP_LDH) && (opKind <= OP_STW);

  a_r1_no_write_on_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && excCode == CAUSE_OVF) |-> !writeEn);

  a_r3_unsigned_clean: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opKind == OP_ADDU || opKind == OP_SUBU || opKind == OP_ADDIU))
      |-> (!excTaken && writeEn));

  a_r5_store_cause: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isStoreKind && excTaken) |-> (excCode == CAUSE_STADR && !writeEn));

  a_r6_jalr_link: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_JALR) |-> (writeEn && writeData == nextPc));

  a_r7_capture_ldst: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isLdStKind && excTaken) |=> (badAddr == $past(opA + immExt)));

  a_r7_capture_jump: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opKind == OP_JR || opKind == OP_JALR) && excTaken)
      |=> (badAddr == $past(opA)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(excTaken && excCode != CAUSE_OVF) |=> $stable(badAddr));

  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!excTaken && !writeEn));

endmodule

bind exec_fault_unit exec_fault_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opKind    (opKind),
  .opA       (opA),
  .immExt    (immExt),
  .nextPc    (nextPc),
  .excTaken  (excTaken),
  .excCode   (excCode),
  .writeEn   (writeEn),
  .writeData (writeData),
  .badAddr   (badAddr)
);

// File: tb/exec_fault_unit_tb_top.sv
`timescale 1ns/1ps
module exec_fault_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opKind = 4'd0;
  logic [31:0] opA = '0, opB = '0, immExt = '0, nextPc = '0;
  logic        excTaken;
  logic [4:0]  excCode;
  logic        writeEn;
  logic [31:0] writeData;
  logic [31:0] badAddr;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] modelBad = '0;
  logic [31:0] vals [16];

  always #2.5 clk = ~clk;

  exec_fault_unit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opA(opA), .opB(opB), .immExt(immExt), .nextPc(nextPc),
    .excTaken(excTaken), .excCode(excCode), .writeEn(writeEn),
    .writeData(writeData), .badAddr(badAddr)
  );

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  function automatic string tagOf(input logic [3:0] k);
    case (k)
      4'd1, 4'd5: return "R1";
      4'd3:       return "R2";
      4'd2, 4'd4, 4'd6: return "R3";
      4'd7, 4'd8, 4'd9, 4'd10: return "R4 R5";
      4'd11, 4'd12: return "R4 R6";
      default:    return "R8";
    endcase
  endfunction

  // drive one operation, check combinational outputs, then the register after the edge
  task automatic runOp(input logic v, input logic [3:0] k, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] imm);
    longint sa, sb, wide;
    logic [31:0] res, addr;
    logic expExc, expWe, addrErr;
    logic [4:0] expCode;
    logic [31:0] expData;
    string tag;
    tag = tagOf(k);
    @(negedge clk);
    opValid = v; opKind = k; opA = a; opB = b; immExt = imm; nextPc = a ^ 32'h0040_1234;
    sa = longint'($signed(a));
    sb = longint'($signed((k == 4'd5 || k == 4'd6) ? imm : b));
    wide = (k == 4'd3 || k == 4'd4) ? sa - sb : sa + sb;
    res = wide[31:0];
    addr = a + imm;
    expExc = 1'b0; expWe = 1'b0; expCode = 5'd0; expData = '0; addrErr = 1'b0;
    if (v) begin
      case (k)
        4'd1, 4'd3, 4'd5: begin
          if (wide > 64'sd2147483647 || wide < -64'sd2147483648) begin
            expExc = 1'b1; expCode = 5'd12;
          end else begin
            expWe = 1'b1; expData = res;
          end
        end
        4'd2, 4'd4, 4'd6: begin expWe = 1'b1; expData = res; end
        4'd7, 4'd9, 4'd8, 4'd10: begin
          addrErr = (k == 4'd7 || k == 4'd9) ? addr[0] : (addr[1:0] != 2'b00);
          if (addrErr) begin
            expExc = 1'b1; expCode = (k >= 4'd9) ? 5'd5 : 5'd4;
          end else if (k <= 4'd8) begin
            expWe = 1'b1; expData = addr;
          end
        end
        4'd11, 4'd12: begin
          addrErr = (a[1:0] != 2'b00);
          addr = a;
          if (addrErr) begin expExc = 1'b1; expCode = 5'd4; end
          if (k == 4'd12) begin expWe = 1'b1; expData = nextPc; end
        end
        default: ;
      endcase
    end
    #1;
    compared++;
    if (excTaken !== expExc || excCode !== expCode || writeEn !== expWe ||
        (expWe && writeData !== expData)) begin
      mismatched++;
      $display("FAIL %s kind=%0d a=%h b=%h imm=%h: actual exc=%b code=%0d we=%b data=%h expected exc=%b code=%0d we=%b data=%h",
               tag, k, a, b, imm, excTaken, excCode, writeEn, writeData,
               expExc, expCode, expWe, expData);
    end
    if (addrErr) modelBad = addr;
    @(posedge clk);
    #1;
    compared++;
    if (badAddr !== modelBad) begin
      mismatched++;
      $display("FAIL R7 kind=%0d: actual badAddr=%h expected %h", k, badAddr, modelBad);
    end
  endtask

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h0000_0002;
    vals[3] = 32'h0000_0003; vals[4] = 32'h7fff_ffff; vals[5] = 32'h8000_0000;
    vals[6] = 32'hffff_ffff; vals[7] = 32'h7fff_fffe; vals[8] = 32'h8000_0001;
    vals[9] = 32'h4000_0000; vals[10] = 32'hc000_0000; vals[11] = 32'h0000_0005;
    vals[12] = 32'hffff_fffe; vals[13] = 32'h1234_5679; vals[14] = 32'h3fff_ffff;
    vals[15] = 32'hbfff_fffe;

    repeat (3) @(posedge clk);
    #1;
    compared++;  // R7 reset value
    if (badAddr !== 32'h0) begin
      mismatched++;
      $display("FAIL R7 reset: actual badAddr=%h expected 00000000", badAddr);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R3: all pairs through every arithmetic kind
    for (int k = 1; k <= 6; k++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          runOp(1'b1, k[3:0], vals[i], vals[j], {{16{vals[j][15]}}, vals[j][15:0]});

    // R4 R5: exhaustive low bits of base and offset for every access width
    for (int k = 7; k <= 10; k++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          runOp(1'b1, k[3:0], 32'h1000_0000 + i, 32'h0, (j < 4) ? j : 32'hffff_fff8 + j);

    // R4 R6: jump targets, with overflow traps between to show R7 hold
    for (int k = 11; k <= 12; k++)
      for (int i = 0; i < 8; i++) begin
        runOp(1'b1, k[3:0], 32'h0040_0100 + i * 32'h11, 32'h0, 32'h0);
        runOp(1'b1, 4'd1, 32'h7fff_ffff, 32'h1, 32'h0);  // R7 overflow must not capture
      end

    // R8: valid low with operations that would fault
    runOp(1'b1, 4'd8, 32'h2000_0002, 32'h0, 32'h0);
    for (int k = 0; k <= 12; k++)
      runOp(1'b0, k[3:0], 32'h7fff_ffff, 32'hffff_ffff, 32'h3);
    runOp(1'b1, 4'd0, 32'h3, 32'h3, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule